// File: doc/BRIEF.md
# Extra Cycle Penalty Evaluator

This block sits beside the microcode sequencer of a processor whose internal datapath is one byte wide but which runs software written for a machine with 16-bit registers. For every instruction it is handed the addressing mode, the operation class, the width and decimal flags, and the low bytes and carries that matter for address and data formation. It decides which extra microcycles the narrow datapath needs beyond the cycle count of the wide machine. A penalty is raised only when a page or bank boundary is actually crossed, or when a mode and flag combination always needs one, so that in the best case the instruction matches the wide machine's timing.

The sequencer presents one evaluation per cycle with `eval_valid`. One clock later the block returns a vector with one bit per penalty condition and a count of the set bits. Each bit can be inspected on its own, and the count is the number of microcycles to insert. Push and pull operations never take a penalty, because a full-width stack pointer incrementer handles them.

Top module: `penalty_eval`

## Requirements
- R1: After a synchronous active-high reset, `res_valid` is 0, `pen_vec` is all zeros and `pen_cnt` is 0.
- R2: `res_valid` is high exactly one cycle after `eval_valid` is high. While `eval_valid` is low, `pen_vec` and `pen_cnt` keep their last values.
- R3: `pen_vec[0]` (direct-page offset crossing) is set when the mode is 4 (direct indexed indirect) or 5 (direct indirect indexed), `dp_lo` is nonzero, and `dp_lo + opnd` carries out of 8 bits.
- R4: `pen_vec[1]` (stack-relative crossing) is set when the mode is 6 (stack relative) and `sp_lo + opnd` carries out of 8 bits.
- R5: `pen_vec[2]` (index into bank) is set when the mode is 5, 7 (stack relative indirect indexed) or 9 (absolute or long indexed) and `idx_bank_cy` is 1.
- R6: `pen_vec[3]` (direct indexing) is set in modes 3 (direct indexed) and 4 whenever `x_flag` is 0. When `x_flag` is 1, it is set only if `opnd + idx_lo` carries out of 8 bits.
- R7: `pen_vec[4]` (data straddles bank) is set when `m_flag` is 0, `data_wrap_cy` is 1, and the mode is one of 2, 3, 4, 5, 7, 8, 9 or 10. Modes 0 (none), 1 (direct) and 6 never set it.
- R8: `pen_vec[5]` (wide step wraps) is set for class 2 (increment) when the register is 16 bits wide and `reg_lo` is 0xFF, and for class 3 (decrement) when it is 16 bits wide and `reg_lo` is 0x00. A register is 16 bits wide when its governing flag is 0: `x_flag` if `sel_idx` is 1, otherwise `m_flag`.
- R9: `pen_vec[6]` (wide transfer) is set for class 4 (transfer) when the destination register, chosen by the rule in R8, is 16 bits wide.
- R10: `pen_vec[7]` (decimal) is set for class 1 (arithmetic) when `d_flag` is 1. Other classes ignore `d_flag`.
- R11: Class 5 (push or pull) yields an all-zero `pen_vec` whatever the mode, flags and carries. Class 0 is a plain operation that adds only address penalties.
- R12: `pen_cnt` equals the number of set bits in `pen_vec`. It reaches 3 for the direct indirect indexed case with a nonzero offset, 16-bit width and all three crossings present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_valid | input | 1 | Evaluate the presented instruction |
| mode | input | 4 | Addressing mode code (0 to 10) |
| op_cls | input | 3 | Operation class (0 to 5) |
| m_flag | input | 1 | Accumulator/memory width flag, 1 = 8-bit |
| x_flag | input | 1 | Index width flag, 1 = 8-bit |
| d_flag | input | 1 | Decimal arithmetic flag |
| sel_idx | input | 1 | Register stepped or written is an index register |
| dp_lo | input | 8 | Direct-page base low byte |
| opnd | input | 8 | Instruction operand byte |
| sp_lo | input | 8 | Stack pointer low byte |
| idx_lo | input | 8 | Low byte of the index register in use |
| reg_lo | input | 8 | Low byte of the register being stepped |
| idx_bank_cy | input | 1 | Indexing carried into the bank byte |
| data_wrap_cy | input | 1 | Second data byte address wrapped into the next bank |
| res_valid | output | 1 | Result registers hold a fresh evaluation |
| pen_vec | output | 8 | One bit per penalty condition |
| pen_cnt | output | 4 | Number of extra microcycles |

## Verification
A wrong decode of a mode or class shows up as a bit of `pen_vec` differing from the expected set one cycle after the offending `eval_valid`, and the count then differs too. Errors in carry formation show only at the exact boundary bytes, so the stimulus sits on both sides of each carry: 0xFF against 0x00 for the stepped register, and sums of exactly 0x100 against 0xFF. A broken hold path shows as `pen_vec` changing during idle cycles, which the bench checks before the next request.

// File: rtl/pen_pkg.sv
package pen_pkg;
  localparam int NPEN  = 8;
  localparam int NADDR = 5;
  localparam int NOP   = 3;

  localparam int P_DP    = 0;
  localparam int P_STK   = 1;
  localparam int P_IDX   = 2;
  localparam int P_DIX   = 3;
  localparam int P_MX    = 4;
  localparam int P_STEP  = 5;
  localparam int P_XFER  = 6;
  localparam int P_DEC   = 7;

  typedef enum logic [3:0] {
    AM_NONE      = 4'd0,
    AM_DIR       = 4'd1,
    AM_DIR_IND   = 4'd2,
    AM_DIR_X     = 4'd3,
    AM_DIR_X_IND = 4'd4,
    AM_DIR_IND_Y = 4'd5,
    AM_STK       = 4'd6,
    AM_STK_IND_Y = 4'd7,
    AM_ABS       = 4'd8,
    AM_ABS_IDX   = 4'd9,
    AM_LONG      = 4'd10
  } amode_t;

  typedef enum logic [2:0] {
    OC_PLAIN = 3'd0,
    OC_ARITH = 3'd1,
    OC_INC   = 3'd2,
    OC_DEC   = 3'd3,
    OC_XFER  = 3'd4,
    OC_STACK = 3'd5
  } opcls_t;
endpackage

// File: rtl/pen_addr_eval.sv
module pen_addr_eval
  import pen_pkg::*;
#(
  parameter int DW = 8
) (
  input  amode_t          mode,
  input  logic            m_flag,
  input  logic            x_flag,
  input  logic [DW-1:0]   dp_lo,
  input  logic [DW-1:0]   opnd,
  input  logic [DW-1:0]   sp_lo,
  input  logic [DW-1:0]   idx_lo,
  input  logic            idx_bank_cy,
  input  logic            data_wrap_cy,
  output logic [NADDR-1:0] addr_pen
);
  logic [DW:0] dp_sum, sp_sum, ix_sum;
  logic use_dp, use_stk, use_idx, use_dix, use_mx;

  assign dp_sum = {1'b0, dp_lo} + {1'b0, opnd};
  assign sp_sum = {1'b0, sp_lo} + {1'b0, opnd};
  assign ix_sum = {1'b0, opnd}  + {1'b0, idx_lo};

  always_comb begin
    use_dp  = 1'b0;
    use_stk = 1'b0;
    use_idx = 1'b0;
    use_dix = 1'b0;
    use_mx  = 1'b0;
    unique case (mode)
      AM_DIR_IND:   use_mx = 1'b1;
      AM_DIR_X:     begin use_dix = 1'b1; use_mx = 1'b1; end
      AM_DIR_X_IND: begin use_dp = 1'b1; use_dix = 1'b1; use_mx = 1'b1; end
      AM_DIR_IND_Y: begin use_dp = 1'b1; use_idx = 1'b1; use_mx = 1'b1; end
      AM_STK:       use_stk = 1'b1;
      AM_STK_IND_Y: begin use_idx = 1'b1; use_mx = 1'b1; end
      AM_ABS:       use_mx = 1'b1;
      AM_ABS_IDX:   begin use_idx = 1'b1; use_mx = 1'b1; end
      AM_LONG:      use_mx = 1'b1;
      default:      ;
    endcase
  end

  always_comb begin
    addr_pen        = '0;
    addr_pen[P_DP]  = use_dp && (dp_lo != '0) && dp_sum[DW];
    addr_pen[P_STK] = use_stk && sp_sum[DW];
    addr_pen[P_IDX] = use_idx && idx_bank_cy;
    addr_pen[P_DIX] = use_dix && (!x_flag || ix_sum[DW]);
    addr_pen[P_MX]  = use_mx && !m_flag && data_wrap_cy;
  end
endmodule

// File: rtl/pen_op_eval.sv
module pen_op_eval
  import pen_pkg::*;
#(
  parameter int DW = 8
) (
  input  opcls_t        cls,
  input  logic          m_flag,
  input  logic          x_flag,
  input  logic          d_flag,
  input  logic          sel_idx,
  input  logic [DW-1:0] reg_lo,
  output logic [NOP-1:0] op_pen
);
  logic wide;
  assign wide = sel_idx ? !x_flag : !m_flag;

  always_comb begin
    op_pen = '0;
    unique case (cls)
      OC_INC:   op_pen[0] = wide && (reg_lo == {DW{1'b1}});
      OC_DEC:   op_pen[0] = wide && (reg_lo == '0);
      OC_XFER:  op_pen[1] = wide;
      OC_ARITH: op_pen[2] = d_flag;
      default:  ;
    endcase
  end
endmodule

// File: rtl/pen_popcount.sv
module pen_popcount #(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] total
);
  logic [CW-1:0] part [0:N];
  assign part[0] = '0;
  for (genvar i = 0; i < N; i++) begin : g_acc
    assign part[i+1] = part[i] + CW'(bits[i]);
  end
  assign total = part[N];
endmodule

// File: rtl/penalty_eval.sv
module penalty_eval
  import pen_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = $clog2(NPEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          eval_valid,
  input  logic [3:0]    mode,
  input  logic [2:0]    op_cls,
  input  logic          m_flag,
  input  logic          x_flag,
  input  logic          d_flag,
  input  logic          sel_idx,
  input  logic [DW-1:0] dp_lo,
  input  logic [DW-1:0] opnd,
  input  logic [DW-1:0] sp_lo,
  input  logic [DW-1:0] idx_lo,
  input  logic [DW-1:0] reg_lo,
  input  logic          idx_bank_cy,
  input  logic          data_wrap_cy,
  output logic          res_valid,
  output logic [NPEN-1:0] pen_vec,
  output logic [CW-1:0] pen_cnt
);
  amode_t           mode_e;
  opcls_t           cls_e;
  logic [NADDR-1:0] addr_pen;
  logic [NOP-1:0]   op_pen;
  logic [NPEN-1:0]  raw_vec;
  logic [NPEN-1:0]  next_vec;
  logic [CW-1:0]    next_cnt;

  assign mode_e = amode_t'(mode);
  assign cls_e  = opcls_t'(op_cls);

  pen_addr_eval #(.DW(DW)) u_addr (
    .mode(mode_e), .m_flag(m_flag), .x_flag(x_flag),
    .dp_lo(dp_lo), .opnd(opnd), .sp_lo(sp_lo), .idx_lo(idx_lo),
    .idx_bank_cy(idx_bank_cy), .data_wrap_cy(data_wrap_cy),
    .addr_pen(addr_pen)
  );

  pen_op_eval #(.DW(DW)) u_op (
    .cls(cls_e), .m_flag(m_flag), .x_flag(x_flag), .d_flag(d_flag),
    .sel_idx(sel_idx), .reg_lo(reg_lo), .op_pen(op_pen)
  );

  assign raw_vec  = {op_pen, addr_pen};
  assign next_vec = (cls_e == OC_STACK) ? '0 : raw_vec;

  pen_popcount #(.N(NPEN), .CW(CW)) u_cnt (
    .bits(next_vec), .total(next_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      pen_vec   <= '0;
      pen_cnt   <= '0;
    end else begin
      res_valid <= eval_valid;
      if (eval_valid) begin
        pen_vec <= next_vec;
        pen_cnt <= next_cnt;
      end
    end
  end
endmodule

// File: rtl/penalty_eval_chk.sv
module penalty_eval_chk
  import pen_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          eval_valid,
  input logic [3:0]    mode,
  input logic [2:0]    op_cls,
  input logic          m_flag,
  input logic          x_flag,
  input logic          d_flag,
  input logic          sel_idx,
  input logic          data_wrap_cy,
  input logic          res_valid,
  input logic [NPEN-1:0] pen_vec,
  input logic [CW-1:0] pen_cnt
);
  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (!res_valid && pen_vec == '0 && pen_cnt == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    eval_valid |=> res_valid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !eval_valid |=> (!res_valid && $stable(pen_vec) && $stable(pen_cnt)));

  a_r11_stack_free: assert property (@(posedge clk) disable iff (rst)
    (eval_valid && op_cls == 3'd5) |=> (pen_vec == '0 && pen_cnt == '0));

  a_r9_wide_xfer: assert property (@(posedge clk) disable iff (rst)
    (eval_valid && op_cls == 3'd4 && !(sel_idx ? x_flag : m_flag)) |=> pen_vec[P_XFER]);

  a_r10_decimal: assert property (@(posedge clk) disable iff (rst)
    (eval_valid && op_cls == 3'd1 && d_flag) |=> pen_vec[P_DEC]);

  a_r7_narrow_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (eval_valid && (m_flag || !data_wrap_cy)) |=> !pen_vec[P_MX]);

  a_r12_count_match: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (pen_cnt == CW'($countones(pen_vec))));

  a_r6_wide_dix: assert property (@(posedge clk) disable iff (rst)
    (eval_valid && !x_flag && op_cls != 3'd5 && (mode == 4'd3 || mode == 4'd4))
      |=> pen_vec[P_DIX]);
endmodule

bind penalty_eval penalty_eval_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .eval_valid(eval_valid), .mode(mode), .op_cls(op_cls),
  .m_flag(m_flag), .x_flag(x_flag), .d_flag(d_flag), .sel_idx(sel_idx),
  .data_wrap_cy(data_wrap_cy), .res_valid(res_valid), .pen_vec(pen_vec),
  .pen_cnt(pen_cnt)
);

// File: tb/tb_penalty_eval.sv
`timescale 1ns/1ps
module tb_penalty_eval;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic eval_valid = 1'b0;
  logic [3:0] mode = '0;
  logic [2:0] op_cls = '0;
  logic m_flag = 1'b1, x_flag = 1'b1, d_flag = 1'b0, sel_idx = 1'b0;
  logic [7:0] dp_lo = '0, opnd = '0, sp_lo = '0, idx_lo = '0, reg_lo = '0;
  logic idx_bank_cy = 1'b0, data_wrap_cy = 1'b0;
  logic res_valid;
  logic [7:0] pen_vec;
  logic [3:0] pen_cnt;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] vec;
    string      tag;
  } exp_t;
  exp_t sb[$];
  logic [7:0] last_vec = '0;

  always #4 clk = ~clk;

  penalty_eval dut (
    .clk(clk), .rst(rst), .eval_valid(eval_valid), .mode(mode), .op_cls(op_cls),
    .m_flag(m_flag), .x_flag(x_flag), .d_flag(d_flag), .sel_idx(sel_idx),
    .dp_lo(dp_lo), .opnd(opnd), .sp_lo(sp_lo), .idx_lo(idx_lo), .reg_lo(reg_lo),
    .idx_bank_cy(idx_bank_cy), .data_wrap_cy(data_wrap_cy),
    .res_valid(res_valid), .pen_vec(pen_vec), .pen_cnt(pen_cnt)
  );

  function automatic int ones(logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += v[i];
    return n;
  endfunction

  // Reference built from the requirement text
  function automatic logic [7:0] expect_vec(
      int md, int cl, bit mf, bit xf, bit df, bit si,
      int dp, int op, int sp, int ix, int rl, bit icy, bit wcy);
    logic [7:0] e = '0;
    bit wide_reg = si ? !xf : !mf;
    if (cl == 5) return '0;                                            // R11
    if ((md == 4 || md == 5) && dp != 0 && (dp + op) > 255) e[0] = 1;  // R3
    if (md == 6 && (sp + op) > 255) e[1] = 1;                          // R4
    if ((md == 5 || md == 7 || md == 9) && icy) e[2] = 1;              // R5
    if ((md == 3 || md == 4) && (!xf || (op + ix) > 255)) e[3] = 1;    // R6
    if (!mf && wcy && md >= 2 && md <= 10 && md != 6) e[4] = 1;         // R7
    if (cl == 2 && wide_reg && rl == 255) e[5] = 1;                    // R8
    if (cl == 3 && wide_reg && rl == 0) e[5] = 1;                      // R8
    if (cl == 4 && wide_reg) e[6] = 1;                                 // R9
    if (cl == 1 && df) e[7] = 1;                                       // R10
    return e;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic send(string tag, int md, int cl, bit mf, bit xf, bit df, bit si,
                      int dp, int op, int sp, int ix, int rl, bit icy, bit wcy);
    exp_t it;
    @(negedge clk);
    eval_valid = 1'b1;
    mode = md[3:0]; op_cls = cl[2:0];
    m_flag = mf; x_flag = xf; d_flag = df; sel_idx = si;
    dp_lo = dp[7:0]; opnd = op[7:0]; sp_lo = sp[7:0]; idx_lo = ix[7:0];
    reg_lo = rl[7:0]; idx_bank_cy = icy; data_wrap_cy = wcy;
    it.vec = expect_vec(md, cl, mf, xf, df, si, dp, op, sp, ix, rl, icy, wcy);
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      eval_valid = 1'b0;
      // change inputs so a missing hold would show (R2)
      mode = 4'd3; x_flag = 1'b0; op_cls = 3'd1; d_flag = 1'b1;
    end
  endtask

  // Monitor: one result per cycle with res_valid
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && res_valid) begin
        exp_t it;
        if (sb.size() == 0) begin
          check(1'b0, "R2", "unexpected res_valid", 1, 0);
        end else begin
          it = sb.pop_front();
          check(pen_vec == it.vec, it.tag, "pen_vec", pen_vec, it.vec);
          check(pen_cnt == 4'(ones(it.vec)), "R12", "pen_cnt", pen_cnt, ones(it.vec));
          last_vec = it.vec;
        end
      end else if (!rst && !res_valid) begin
        if (total > 3) check(pen_vec == last_vec, "R2", "hold while idle", pen_vec, last_vec);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0, "R1", "res_valid after reset", res_valid, 0);
    check(pen_vec == '0, "R1", "pen_vec after reset", pen_vec, 0);
    check(pen_cnt == '0, "R1", "pen_cnt after reset", pen_cnt, 0);
    rst = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b0, "R2", "no result without request", res_valid, 0);

    // R12: all three crossings on (dir),Y style mode, count 3
    send("R12", 5, 0, 0, 0, 0, 0, 8'h10, 8'hF8, 0, 0, 0, 1, 1);
    // R3: offset zero -> no page penalty
    send("R3", 5, 0, 0, 0, 0, 0, 8'h00, 8'hFF, 0, 0, 0, 0, 0);
    // R3: sum exactly 0xFF, no carry
    send("R3", 4, 0, 0, 1, 0, 0, 8'h0F, 8'hF0, 0, 0, 0, 0, 0);
    // R3: sum 0x100
    send("R3", 4, 0, 1, 1, 0, 0, 8'h10, 8'hF0, 0, 0, 0, 0, 0);
    idle(3);
    // R4 stack relative
    send("R4", 6, 0, 0, 1, 0, 0, 0, 8'h20, 8'hF0, 0, 0, 0, 1);
    send("R4", 6, 0, 1, 1, 0, 0, 0, 8'h05, 8'hF0, 0, 0, 0, 0);
    // R5 index into bank
    send("R5", 7, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    send("R5", 9, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    send("R5", 8, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R6 direct indexed
    send("R6", 3, 0, 1, 0, 0, 0, 0, 8'h10, 0, 8'h20, 0, 0, 0);
    send("R6", 3, 0, 1, 1, 0, 0, 0, 8'hF0, 0, 8'h20, 0, 0, 0);
    send("R6", 3, 0, 1, 1, 0, 0, 0, 8'h10, 0, 8'h20, 0, 0, 0);
    // R7 data straddle
    send("R7", 8, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    send("R7", 8, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    send("R7", 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    send("R7", 10, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    idle(2);
    // R8 wide step wrap
    send("R8", 0, 2, 1, 0, 0, 1, 0, 0, 0, 0, 8'hFF, 0, 0);
    send("R8", 0, 2, 0, 1, 0, 1, 0, 0, 0, 0, 8'hFF, 0, 0);
    send("R8", 0, 3, 0, 1, 0, 0, 0, 0, 0, 0, 8'h00, 0, 0);
    send("R8", 0, 3, 0, 1, 0, 0, 0, 0, 0, 0, 8'h01, 0, 0);
    send("R8", 0, 2, 0, 0, 0, 0, 0, 0, 0, 0, 8'hFE, 0, 0);
    // R9 transfer
    send("R9", 0, 4, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    send("R9", 0, 4, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    send("R9", 0, 4, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    // R10 decimal
    send("R10", 0, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    send("R10", 0, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    send("R10", 0, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R11 push/pull with every condition that could fire
    send("R11", 4, 5, 0, 0, 1, 0, 8'h80, 8'h90, 0, 0, 8'hFF, 1, 1);
    send("R11", 6, 5, 0, 0, 1, 1, 0, 8'hFF, 8'hFF, 0, 0, 1, 1);
    // R12 four conditions together
    send("R12", 4, 1, 0, 0, 1, 0, 8'h80, 8'h90, 0, 0, 0, 0, 1);
    idle(4);
    check(sb.size() == 0, "R2", "results outstanding", sb.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule